// File: doc/BRIEF.md
# Serial Converter Control-Byte Front End

This block is the device-side digital front end of an eight-input serial data converter. The host frames a transaction by pulling chip select low and clocking bits in on the serial data input. The block skips every leading zero and treats the first one bit as the start of an eight-bit control word. It splits that word into an input-select code, a polarity flag, a single-ended/differential flag and a two-bit operating mode, and holds each field on a parallel output until the next complete word arrives.

When the decoded mode asks for an externally clocked conversion, the block raises a strobe for one serial clock period. It then shifts a 12-bit parallel result out on the serial data output, most significant bit first, one bit per serial clock. A new control word can be received while the previous result is still being shifted out, so conversions can follow each other every 15 serial clocks. Raising chip select abandons any partial word or readout in progress.

Top module: `adc_serial_frontend`

## Requirements
- R1: Serial input bits are taken on the rising edge of `sclk`, and only while `cs_n` is low. Bits presented while `cs_n` is high change no field and start no readout.
- R2: After `cs_n` goes low, and again after each completed word, every 0 bit is skipped. The first 1 bit is the start bit, and it is bit 7 of the control word.
- R3: The seven bits that follow the start bit are bits 6 down to 0. Bits 6:4 drive `chan_sel`, bit 3 drives `unipolar` (1 = unipolar, 0 = bipolar) and bit 2 drives `single_ended` (1 = single-ended, 0 = differential). All fields update at the rising edge that takes bit 0 and hold until the next complete word.
- R4: Bits 1:0 drive `pwr_mode`: 00 full power-down, 01 fast power-down, 10 internal clock, 11 external clock. Only 11 starts a serial readout.
- R5: In mode 11, `sstrb` is high for exactly one `sclk` period. That period begins at the falling edge right after the rising edge that took bit 0.
- R6: `result_in` is sampled at the falling edge that raises `sstrb`. Its 12 bits then appear on `dout`, MSB first, at the next 12 falling edges, and `dout` is 0 after the LSB and at every other time.
- R7: While `cs_n` is low, `dout` and `sstrb` change only at falling edges of `sclk`.
- R8: Words that start every 15 `sclk` cycles each produce a full, correct strobe and readout.
- R9: Raising `cs_n` drops any partial word and any readout in progress, forces `dout` and `sstrb` to 0 while high, and returns the receiver to start-bit search.
- R10: A start bit received during a readout begins a new word without disturbing that readout. A word in mode 11 that completes while result bits are still pending (fewer than 13 cycles after the previous one) updates the fields but starts no new readout.
- R11: Synchronous reset `rst` clears all fields to 0 (mode full power-down) and drives `dout` and `sstrb` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; input sampled on rise, outputs driven on fall |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial control input |
| result_in | input | 12 | Parallel conversion result to be shifted out |
| dout | output | 1 | Serial result output |
| sstrb | output | 1 | One-period strobe ahead of the result MSB |
| chan_sel | output | 3 | Decoded input-select code |
| unipolar | output | 1 | 1 = unipolar, 0 = bipolar |
| single_ended | output | 1 | 1 = single-ended, 0 = differential |
| pwr_mode | output | 2 | Decoded operating mode |

## Verification
Reception of a new control word and shifting of the previous result share `sclk` cycles. The hardest case is a word whose last bit lands on the same falling edge as the final result bit. The bench sends external-clock words 15, 13 and 12 cycles apart. A scoreboard compares every cycle's `sstrb` and `dout` against a queue of expected items. With 12-cycle spacing, the second word must update the fields while the readout ends untouched and no second strobe appears. With 13-cycle spacing, the second strobe must follow directly after the trailing zero.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

    localparam int CH_BITS  = 3;
    localparam int CB_BITS  = CH_BITS + 5;
    localparam int RES_BITS = 12;

    typedef enum logic [1:0] {
        MODE_FULL_PD = 2'b00,
        MODE_FAST_PD = 2'b01,
        MODE_INT_CLK = 2'b10,
        MODE_EXT_CLK = 2'b11
    } pmode_e;

    typedef struct packed {
        logic [CH_BITS-1:0] chan;
        logic               unipolar;
        logic               single_ended;
        pmode_e             mode;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        chan:         '0,
        unipolar:     1'b0,
        single_ended: 1'b0,
        mode:         MODE_FULL_PD
    };

    // Word below the start bit, bit (CB_BITS-2) down to bit 0.
    function automatic ctrl_t decode_ctrl(input logic [CB_BITS-2:0] body);
        ctrl_t d;
        d.chan         = body[CB_BITS-2 -: CH_BITS];
        d.unipolar     = body[3];
        d.single_ended = body[2];
        d.mode         = pmode_e'(body[1:0]);
        return d;
    endfunction

endpackage

// File: rtl/adc_cb_rx.sv
module adc_cb_rx
    import adc_fe_pkg::*;
#(
    parameter int WORD_BITS = CB_BITS
) (
    input  logic  sclk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  din,
    output logic  word_done,
    output ctrl_t ctrl
);

    localparam int BODY_W = WORD_BITS - 2;
    localparam int CNT_W  = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BODY_W-1:0] body_q;
    logic              take_last;

    assign take_last = !cs_n && (bit_cnt == LAST);

    // bit_cnt == 0 means searching for the start bit
    always_ff @(posedge sclk) begin
        if (rst || cs_n) begin
            bit_cnt   <= '0;
            word_done <= 1'b0;
            body_q    <= '0;
        end else begin
            word_done <= 1'b0;
            if (bit_cnt == '0) begin
                if (din) begin
                    bit_cnt <= CNT_W'(1);
                end
            end else begin
                body_q <= {body_q[BODY_W-2:0], din};
                if (bit_cnt == LAST) begin
                    bit_cnt   <= '0;
                    word_done <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge sclk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
        end else if (take_last) begin
            ctrl <= decode_ctrl({body_q, din});
        end
    end

    AST_WORD_FRAMED: assert property (@(posedge sclk) disable iff (rst)
        word_done |-> ($past(bit_cnt) == LAST && !$past(cs_n))) else $error("frame length"); // R2
    AST_DONE_PULSE: assert property (@(posedge sclk) disable iff (rst)
        word_done |=> !word_done) else $error("done pulse"); // R3

endmodule

// File: rtl/adc_res_tx.sv
module adc_res_tx
    import adc_fe_pkg::*;
#(
    parameter int RES_W = RES_BITS
) (
    input  logic             sclk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             word_done,
    input  logic             ext_mode,
    input  logic [RES_W-1:0] result_in,
    output logic             sstrb_q,
    output logic             dout_q
);

    localparam int CNT_W = $clog2(RES_W + 1);

    logic [RES_W-1:0] shreg;
    logic [CNT_W-1:0] left;

    always_ff @(negedge sclk) begin
        if (rst || cs_n) begin
            sstrb_q <= 1'b0;
            dout_q  <= 1'b0;
            shreg   <= '0;
            left    <= '0;
        end else begin
            sstrb_q <= 1'b0;
            if (left != '0) begin
                dout_q <= shreg[RES_W-1];
                shreg  <= {shreg[RES_W-2:0], 1'b0};
                left   <= left - CNT_W'(1);
            end else begin
                dout_q <= 1'b0;
                if (word_done && ext_mode) begin
                    sstrb_q <= 1'b1;
                    shreg   <= result_in;
                    left    <= CNT_W'(RES_W);
                end
            end
        end
    end

    AST_STRB_ONE_PERIOD: assert property (@(negedge sclk) disable iff (rst)
        sstrb_q |=> !sstrb_q) else $error("strobe width"); // R5
    AST_BITS_AFTER_STRB: assert property (@(negedge sclk) disable iff (rst)
        ($fell(sstrb_q) && !cs_n) |-> (left == CNT_W'(RES_W - 1))) else $error("msb slot"); // R6
    AST_TRAIL_ZERO: assert property (@(negedge sclk) disable iff (rst)
        (left == '0 && !sstrb_q && !cs_n) |=> !dout_q) else $error("trailing zero"); // R6
    AST_BUSY_NO_RESTART: assert property (@(negedge sclk) disable iff (rst)
        (word_done && left > CNT_W'(1) && !cs_n) |=> !sstrb_q) else $error("busy restart"); // R10

endmodule

// File: rtl/adc_serial_frontend.sv
module adc_serial_frontend
    import adc_fe_pkg::*;
(
    input  logic                sclk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                din,
    input  logic [RES_BITS-1:0] result_in,
    output logic                dout,
    output logic                sstrb,
    output logic [CH_BITS-1:0]  chan_sel,
    output logic                unipolar,
    output logic                single_ended,
    output logic [1:0]          pwr_mode
);

    ctrl_t ctrl;
    logic  word_done;
    logic  sstrb_q;
    logic  dout_q;

    adc_cb_rx #(.WORD_BITS(CB_BITS)) u_rx (
        .sclk      (sclk),
        .rst       (rst),
        .cs_n      (cs_n),
        .din       (din),
        .word_done (word_done),
        .ctrl      (ctrl)
    );

    adc_res_tx #(.RES_W(RES_BITS)) u_tx (
        .sclk      (sclk),
        .rst       (rst),
        .cs_n      (cs_n),
        .word_done (word_done),
        .ext_mode  (ctrl.mode == MODE_EXT_CLK),
        .result_in (result_in),
        .sstrb_q   (sstrb_q),
        .dout_q    (dout_q)
    );

    // Outputs are forced low as soon as chip select rises
    assign dout         = dout_q  & ~cs_n;
    assign sstrb        = sstrb_q & ~cs_n;
    assign chan_sel     = ctrl.chan;
    assign unipolar     = ctrl.unipolar;
    assign single_ended = ctrl.single_ended;
    assign pwr_mode     = ctrl.mode;

endmodule

// File: tb/adc_serial_frontend_tb.sv
`timescale 1ns/100ps
module adc_serial_frontend_tb;

    logic        sclk = 1'b0;
    logic        rst  = 1'b1;
    logic        cs_n = 1'b1;
    logic        din  = 1'b0;
    logic [11:0] result_in = '0;
    logic        dout, sstrb, unipolar, single_ended;
    logic [2:0]  chan_sel;
    logic [1:0]  pwr_mode;

    adc_serial_frontend u_dut (
        .sclk(sclk), .rst(rst), .cs_n(cs_n), .din(din), .result_in(result_in),
        .dout(dout), .sstrb(sstrb), .chan_sel(chan_sel), .unipolar(unipolar),
        .single_ended(single_ended), .pwr_mode(pwr_mode)
    );

    always #2 sclk = ~sclk;

    int cyc = 0;
    always @(posedge sclk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;
    int busy_end = -100;
    bit mon_on = 1'b0;
    string idle_tag = "R6";

    typedef struct {
        int    at;
        logic  s;
        logic  d;
        string req;
    } exp_t;
    exp_t q[$];
    exp_t e;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard in the cycle an item is due, else expects quiet outputs
    logic s_smp, d_smp;
    always @(posedge sclk) begin
        if (mon_on) begin
            #1;
            s_smp = sstrb;
            d_smp = dout;
            if (q.size() != 0 && q[0].at == cyc) begin
                e = q.pop_front();
                check(s_smp == e.s, e.req, "sstrb", s_smp, e.s);
                check(d_smp == e.d, e.req, "dout", d_smp, e.d);
            end else begin
                check(s_smp == 1'b0 && d_smp == 1'b0, idle_tag, "quiet outputs",
                      {s_smp, d_smp}, 0);
            end
            #0.5;
            if (!cs_n)
                check(sstrb == s_smp && dout == d_smp, "R7", "stable between edges",
                      {sstrb, dout}, {s_smp, d_smp});
        end
    end

    task automatic cs_set(input logic v);
        @(posedge sclk);
        #1.8;
        cs_n = v;
        if (v) begin
            q.delete();
            busy_end = -100;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge sclk);
    endtask

    // Driver: zeros, then the word; pushes the expected strobe and bits
    task automatic send_word(input logic [7:0] w, input int zeros, input logic [11:0] res);
        int p;
        for (int i = 0; i < zeros; i++) begin
            @(negedge sclk);
            din = 1'b0;
        end
        for (int i = 7; i >= 0; i--) begin
            @(negedge sclk);
            din = w[i];
            if (i == 7) begin
                #0.5;
                result_in = res;
            end
        end
        @(posedge sclk);
        #0.5;
        din = 1'b0;
        p = cyc;
        check(chan_sel == w[6:4], "R3", "chan_sel", chan_sel, w[6:4]);
        check(unipolar == w[3], "R3", "unipolar", unipolar, w[3]);
        check(single_ended == w[2], "R3", "single_ended", single_ended, w[2]);
        check(pwr_mode == w[1:0], "R4", "pwr_mode", pwr_mode, w[1:0]);
        if (w[1:0] == 2'b11 && p > busy_end) begin
            q.push_back('{at: p + 1, s: 1'b1, d: 1'b0, req: "R5"});
            for (int k = 0; k < 12; k++)
                q.push_back('{at: p + 2 + k, s: 1'b0, d: res[11-k], req: "R6"});
            busy_end = p + 12;
        end
    endtask

    task automatic send_bits(input logic [7:0] w, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge sclk);
            din = w[i];
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge sclk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        idle(3);
        #0.5;
        rst = 1'b0;
        // R11: reset state
        check(chan_sel == 3'd0 && unipolar == 1'b0 && single_ended == 1'b0,
              "R11", "fields after reset", {chan_sel, unipolar, single_ended}, 0);
        check(pwr_mode == 2'b00, "R11", "mode after reset", pwr_mode, 0);
        check(dout == 1'b0 && sstrb == 1'b0, "R11", "outputs after reset", {dout, sstrb}, 0);
        mon_on = 1'b1;

        cs_set(1'b0);
        // basic external readout
        send_word(8'b1_101_1_1_11, 3, 12'hA5C);
        idle(16);
        // R2: long run of leading zeros
        send_word(8'b1_010_0_0_11, 20, 12'h3F1);
        idle(16);
        // R4: the other three modes never read out
        idle_tag = "R4";
        send_word(8'b1_111_1_0_10, 2, 12'hFFF);
        idle(16);
        send_word(8'b1_000_0_1_01, 2, 12'hFFF);
        idle(16);
        send_word(8'b1_011_1_1_00, 2, 12'hFFF);
        idle(16);
        // R8: 15-cycle spacing, start bits arrive during readouts (R10)
        idle_tag = "R8";
        send_word(8'b1_001_1_1_11, 1, 12'h801);
        send_word(8'b1_110_0_1_11, 7, 12'h7FE);
        send_word(8'b1_100_1_0_11, 7, 12'hC33);
        idle(16);
        // R10: 12-cycle spacing ignored, 13-cycle spacing accepted
        idle_tag = "R10";
        send_word(8'b1_010_1_1_11, 0, 12'h5A5);
        send_word(8'b1_111_0_0_11, 4, 12'hFFF);
        idle(16);
        send_word(8'b1_011_0_1_11, 0, 12'h00F);
        send_word(8'b1_100_1_1_11, 5, 12'hF00);
        idle(16);
        // R9: abort a readout; R1: din ignored while deselected
        idle_tag = "R9";
        send_word(8'b1_110_1_1_11, 1, 12'hABC);
        idle(5);
        cs_set(1'b1);
        for (int i = 0; i < 10; i++) begin
            @(negedge sclk);
            din = 1'b1;
        end
        @(negedge sclk);
        din = 1'b0;
        cs_set(1'b0);
        idle(16);
        idle_tag = "R1";
        check(chan_sel == 3'b110 && pwr_mode == 2'b11, "R1", "fields kept while deselected",
              {chan_sel, pwr_mode}, {3'b110, 2'b11});
        // R9: partial word dropped by chip select
        idle_tag = "R9";
        send_bits(8'b1_111_0_0_00, 4);
        cs_set(1'b1);
        din = 1'b0;
        cs_set(1'b0);
        send_word(8'b1_001_0_1_11, 2, 12'h9C6);
        idle(20);
        summary();
    end

endmodule